// File: doc/BRIEF.md
# Dual-Rail Power Sequencer and Fault Supervisor

This block is the digital supervisor for a supply that produces one positive and one negative output rail. It takes an enable level, an undervoltage-lockout flag, an over-temperature flag and four comparator flags from the analog rails. From these it drives the run enables for each rail, a soft-start request for the positive converter, discharge enables for both outputs, and a latched fault report. Millisecond timing is counted from a one-cycle `tick_i` strobe, so the core clock can be any rate.

When the block is enabled, the positive rail starts first in soft start. At the first check point the negative rail is started if the positive rail is healthy. At the second check point the negative rail must be in regulation. After that, both rails are watched for sustained shorts. Any fault stops both converters and latches. The latch is released only by taking enable low or by a lockout event. The report code is kept until the next start attempt begins.

Top module: `rail_supervisor`

## Requirements
- R1: After reset, and one cycle after `en_i` goes low in any state, both run enables and `fault_o` are 0. `fault_o` is also 0 while the block is off.
- R2: In the off state, when `en_i` is 1 and `uvlo_i` is 0 at a clock edge, `pos_run_o` and `soft_start_o` become 1 and `neg_run_o` stays 0.
- R3: At the tick edge that completes NEG_DELAY_MS ticks (default 10) since start, if `pos_ok_i`=1 and `neg_high_i`=0, the block does three things: `neg_run_o` becomes 1, `soft_start_o` becomes 0, and `pos_run_o` stays 1. Before that edge, `neg_run_o` stays 0.
- R4: At that same check edge, `pos_ok_i`=0 raises a fault with code 1. Otherwise, `neg_high_i`=1 raises a fault with code 2. The positive check has priority.
- R5: At the tick edge that completes CHECK_MS ticks (default 20) since start, `neg_ok_i`=0 raises a fault with code 3. Otherwise, both rails stay running in normal operation.
- R6: In normal operation, `pos_short_i` held at 1 across SHORT_MS consecutive ticks (default 3) raises a fault with code 4. Any clock edge that samples the flag at 0 restarts the count from zero.
- R7: In normal operation, `neg_high_i` held at 1 across SHORT_MS consecutive ticks raises a fault with code 5. When both short detectors trip at the same edge, code 4 wins.
- R8: `otp_i`=1 while running or starting, with `en_i`=1 and `uvlo_i`=0, raises a fault with code 6 at the next edge. This takes priority over the check points.
- R9: A fault sets `fault_o`=1 and turns off both run enables. It stays that way while `en_i` stays 1. Taking `en_i` low clears `fault_o` but keeps `fault_code_o`. The code returns to 0 when the next start begins.
- R10: `uvlo_i`=1 forces the off state at the next edge from any state, whatever `en_i` is. When `uvlo_i` returns to 0 with `en_i`=1, a new start begins.
- R11: `pos_dis_o` and `neg_dis_o` are 1 exactly when the block is off or faulted, and 0 while starting or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle millisecond strobe |
| en_i | input | 1 | Enable level |
| uvlo_i | input | 1 | Supply below lockout threshold |
| otp_i | input | 1 | Over-temperature flag |
| pos_ok_i | input | 1 | Positive rail in regulation |
| pos_short_i | input | 1 | Positive rail below short threshold |
| neg_high_i | input | 1 | Negative rail above its threshold |
| neg_ok_i | input | 1 | Negative rail in regulation |
| pos_run_o | output | 1 | Positive converter run enable |
| neg_run_o | output | 1 | Negative converter run enable |
| soft_start_o | output | 1 | Reduced current limit for positive converter |
| pos_dis_o | output | 1 | Positive output discharge enable |
| neg_dis_o | output | 1 | Negative output discharge enable |
| fault_o | output | 1 | Latched fault state |
| fault_code_o | output | 3 | Cause: 0 none, 1 positive start, 2 negative start threshold, 3 negative start regulation, 4 positive short, 5 negative short, 6 thermal |

## Verification
Several properties are checked by the assertions on every cycle:
- rail ordering (the negative rail never runs without the positive rail, and only ever starts out of soft start);
- lockout forcing the rails off;
- discharge being the complement of running;
- the fault latch holding while enable stays high;
- thermal shutdown;
- a nonzero cause whenever a fault is entered.

Other behaviour can only be shown by the directed scenarios:
- the exact tick counts at the two start-up check points;
- the cause codes and their priority;
- the restart of the short timer when its flag drops;
- the retention of the code until the next start.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_START_POS,
    ST_START_NEG,
    ST_RUN,
    ST_FAULT
  } sup_state_e;

  typedef enum logic [2:0] {
    FC_NONE      = 3'd0,
    FC_POS_START = 3'd1,
    FC_NEG_THR   = 3'd2,
    FC_NEG_REG   = 3'd3,
    FC_POS_SHORT = 3'd4,
    FC_NEG_SHORT = 3'd5,
    FC_THERMAL   = 3'd6
  } fault_code_e;

endpackage

// File: rtl/start_timer.sv
module start_timer #(
  parameter int unsigned LIMIT = 20,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (!run_i)                              cnt_q <= '0;
    else if (tick_i && cnt_q < CW'(LIMIT))        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/short_filter.sv
module short_filter #(
  parameter int unsigned LIMIT = 3,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic flag_i,
  input  logic tick_i,
  output logic trip_o
);

  logic [CW-1:0] cnt_q;

  // count is not accumulated: any low sample restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     cnt_q <= '0;
    else if (!active_i || !flag_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q < CW'(LIMIT - 1))       cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = active_i && flag_i && tick_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int unsigned NEG_DELAY_MS = 10,
  parameter int unsigned CHECK_MS     = 20,
  parameter int unsigned SHORT_MS     = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       uvlo_i,
  input  logic       otp_i,
  input  logic       pos_ok_i,
  input  logic       pos_short_i,
  input  logic       neg_high_i,
  input  logic       neg_ok_i,
  output logic       pos_run_o,
  output logic       neg_run_o,
  output logic       soft_start_o,
  output logic       pos_dis_o,
  output logic       neg_dis_o,
  output logic       fault_o,
  output logic [2:0] fault_code_o
);

  localparam int unsigned TW = $clog2(CHECK_MS + 1);
  localparam int unsigned NUM_SHORT = 2;

  sup_state_e    state_q, state_d;
  fault_code_e   code_q, code_d;
  logic [TW-1:0] ms_cnt;
  logic          at_neg, at_check;
  logic          starting, running;
  logic [NUM_SHORT-1:0] short_flag, short_trip;

  assign starting = (state_q == ST_START_POS) || (state_q == ST_START_NEG);
  assign running  = (state_q == ST_RUN);

  start_timer #(.LIMIT(CHECK_MS)) u_start_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (starting),
    .tick_i (tick_i),
    .cnt_o  (ms_cnt)
  );

  assign at_neg   = tick_i && (ms_cnt == TW'(NEG_DELAY_MS - 1));
  assign at_check = tick_i && (ms_cnt == TW'(CHECK_MS - 1));

  // index 0 has priority: positive rail short
  assign short_flag = {neg_high_i, pos_short_i};

  for (genvar g = 0; g < NUM_SHORT; g++) begin : g_short
    short_filter #(.LIMIT(SHORT_MS)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (running),
      .flag_i   (short_flag[g]),
      .tick_i   (tick_i),
      .trip_o   (short_trip[g])
    );
  end

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (uvlo_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (en_i) begin
            state_d = ST_START_POS;
            code_d  = FC_NONE;
          end
        end
        ST_FAULT: begin
          if (!en_i) state_d = ST_OFF;
        end
        default: begin
          if (!en_i) begin
            state_d = ST_OFF;
          end else if (otp_i) begin
            state_d = ST_FAULT;
            code_d  = FC_THERMAL;
          end else begin
            unique case (state_q)
              ST_START_POS: begin
                if (at_neg) begin
                  if (!pos_ok_i) begin
                    state_d = ST_FAULT;
                    code_d  = FC_POS_START;
                  end else if (neg_high_i) begin
                    state_d = ST_FAULT;
                    code_d  = FC_NEG_THR;
                  end else begin
                    state_d = ST_START_NEG;
                  end
                end
              end
              ST_START_NEG: begin
                if (at_check) begin
                  if (!neg_ok_i) begin
                    state_d = ST_FAULT;
                    code_d  = FC_NEG_REG;
                  end else begin
                    state_d = ST_RUN;
                  end
                end
              end
              ST_RUN: begin
                if (short_trip[0]) begin
                  state_d = ST_FAULT;
                  code_d  = FC_POS_SHORT;
                end else if (short_trip[1]) begin
                  state_d = ST_FAULT;
                  code_d  = FC_NEG_SHORT;
                end
              end
              default: state_d = ST_OFF;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      code_q  <= FC_NONE;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign pos_run_o    = starting || running;
  assign neg_run_o    = (state_q == ST_START_NEG) || running;
  assign soft_start_o = (state_q == ST_START_POS);
  assign pos_dis_o    = (state_q == ST_OFF) || (state_q == ST_FAULT);
  assign neg_dis_o    = pos_dis_o;
  assign fault_o      = (state_q == ST_FAULT);
  assign fault_code_o = code_q;

endmodule

// File: rtl/rail_supervisor_checker.sv
module rail_supervisor_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       en_i,
  input logic       uvlo_i,
  input logic       otp_i,
  input logic       pos_ok_i,
  input logic       pos_short_i,
  input logic       neg_high_i,
  input logic       neg_ok_i,
  input logic       pos_run_o,
  input logic       neg_run_o,
  input logic       soft_start_o,
  input logic       pos_dis_o,
  input logic       neg_dis_o,
  input logic       fault_o,
  input logic [2:0] fault_code_o
);

  assert_neg_needs_pos_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_run_o |-> pos_run_o);

  assert_soft_start_pos_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_start_o |-> (pos_run_o && !neg_run_o));

  assert_neg_after_soft_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(neg_run_o) |-> $past(soft_start_o));

  assert_uvlo_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (!pos_run_o && !neg_run_o && !fault_o));

  assert_discharge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_dis_o == !pos_run_o) && (neg_dis_o == !pos_run_o));

  assert_fault_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i && !uvlo_i) |=> (fault_o && $stable(fault_code_o)));

  assert_fault_rails_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!pos_run_o && !neg_run_o));

  assert_thermal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (otp_i && pos_run_o && en_i && !uvlo_i) |=> (fault_o && fault_code_o == 3'd6));

  assert_fault_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> (fault_code_o != 3'd0));

  assert_enable_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pos_run_o && !fault_o));

endmodule

bind rail_supervisor rail_supervisor_checker u_rail_supervisor_checker (.*);

// File: tb/rail_supervisor_bench.sv
`timescale 1ns/1ps
module rail_supervisor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       en_i = 1'b0;
  logic       uvlo_i = 1'b0;
  logic       otp_i = 1'b0;
  logic       pos_ok_i = 1'b0;
  logic       pos_short_i = 1'b0;
  logic       neg_high_i = 1'b0;
  logic       neg_ok_i = 1'b0;
  logic       pos_run_o, neg_run_o, soft_start_o, pos_dis_o, neg_dis_o, fault_o;
  logic [2:0] fault_code_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rail_supervisor u_rail_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .en_i(en_i), .uvlo_i(uvlo_i),
    .otp_i(otp_i), .pos_ok_i(pos_ok_i), .pos_short_i(pos_short_i),
    .neg_high_i(neg_high_i), .neg_ok_i(neg_ok_i), .pos_run_o(pos_run_o),
    .neg_run_o(neg_run_o), .soft_start_o(soft_start_o), .pos_dis_o(pos_dis_o),
    .neg_dis_o(neg_dis_o), .fault_o(fault_o), .fault_code_o(fault_code_o)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic healthy_flags();
    pos_ok_i = 1'b1; neg_ok_i = 1'b1; neg_high_i = 1'b0;
    pos_short_i = 1'b0; otp_i = 1'b0; uvlo_i = 1'b0;
  endtask

  task automatic shut_down();
    en_i = 1'b0;
    healthy_flags();
    step();
  endtask

  task automatic goto_run();
    shut_down();
    en_i = 1'b1;
    step();
    ticks(20);
  endtask

  task automatic t_reset();
    chk(pos_run_o, 0, "R1 reset pos_run");
    chk(neg_run_o, 0, "R1 reset neg_run");
    chk(fault_o, 0, "R1 reset fault");
    chk(fault_code_o, 0, "R1 reset code");
    chk(pos_dis_o & neg_dis_o, 1, "R11 reset discharge");
  endtask

  task automatic t_normal_start();
    shut_down();
    en_i = 1'b1;
    step();
    chk(pos_run_o, 1, "R2 pos_run on enable");
    chk(soft_start_o, 1, "R2 soft_start on enable");
    chk(neg_run_o, 0, "R2 neg_run held off");
    chk(pos_dis_o, 0, "R11 discharge off while starting");
    ticks(9);
    chk(neg_run_o, 0, "R3 neg_run before 10th tick");
    ticks(1);
    chk(neg_run_o, 1, "R3 neg_run after 10th tick");
    chk(soft_start_o, 0, "R3 soft_start ends");
    ticks(10);
    chk(fault_o, 0, "R5 no fault at 20th tick");
    chk(pos_run_o & neg_run_o, 1, "R5 both rails running");
    en_i = 1'b0;
    step();
    chk(pos_run_o | neg_run_o, 0, "R1 enable low stops rails");
    chk(neg_dis_o, 1, "R11 discharge when disabled");
  endtask

  task automatic t_start_faults();
    shut_down();
    pos_ok_i = 1'b0;
    neg_high_i = 1'b1;
    en_i = 1'b1;
    step();
    ticks(10);
    chk(fault_code_o, 1, "R4 positive start fault wins");
    chk(fault_o, 1, "R4 fault flag");
    shut_down();
    neg_high_i = 1'b1;
    en_i = 1'b1;
    step();
    ticks(10);
    chk(fault_code_o, 2, "R4 negative threshold fault");
    shut_down();
    neg_ok_i = 1'b0;
    en_i = 1'b1;
    step();
    ticks(19);
    chk(fault_o, 0, "R5 no fault before 20th tick");
    ticks(1);
    chk(fault_code_o, 3, "R5 negative regulation fault");
    chk(neg_run_o, 0, "R9 neg off on fault");
  endtask

  task automatic t_pos_short();
    goto_run();
    pos_short_i = 1'b1;
    ticks(2);
    pos_short_i = 1'b0;
    step();
    pos_short_i = 1'b1;
    ticks(2);
    chk(fault_o, 0, "R6 timer restarted after flag drop");
    ticks(1);
    chk(fault_code_o, 4, "R6 positive short fault");
    chk(pos_dis_o & neg_dis_o, 1, "R11 discharge on fault");
    pos_short_i = 1'b0;
    step(30);
    chk(fault_o, 1, "R9 fault held with enable high");
    en_i = 1'b0;
    step();
    chk(fault_o, 0, "R9 fault cleared by enable low");
    chk(fault_code_o, 4, "R9 code kept while off");
    en_i = 1'b1;
    step();
    chk(fault_code_o, 0, "R9 code cleared on new start");
    chk(pos_run_o, 1, "R9 restart after toggle");
  endtask

  task automatic t_neg_short();
    goto_run();
    neg_high_i = 1'b1;
    ticks(2);
    chk(fault_o, 0, "R7 no fault after two ticks");
    ticks(1);
    chk(fault_code_o, 5, "R7 negative short fault");
    goto_run();
    neg_high_i = 1'b1;
    pos_short_i = 1'b1;
    ticks(3);
    chk(fault_code_o, 4, "R7 positive short priority");
  endtask

  task automatic t_thermal();
    goto_run();
    otp_i = 1'b1;
    step();
    chk(fault_code_o, 6, "R8 thermal fault in run");
    chk(pos_run_o | neg_run_o, 0, "R8 rails off");
    shut_down();
    en_i = 1'b1;
    step();
    otp_i = 1'b1;
    pos_ok_i = 1'b0;
    ticks(10);
    chk(fault_code_o, 6, "R8 thermal beats start check");
  endtask

  task automatic t_uvlo();
    goto_run();
    uvlo_i = 1'b1;
    step();
    chk(pos_run_o | neg_run_o, 0, "R10 lockout stops rails");
    chk(pos_dis_o, 1, "R11 discharge in lockout");
    step(5);
    chk(pos_run_o, 0, "R10 held off with enable high");
    uvlo_i = 1'b0;
    step();
    chk(soft_start_o, 1, "R10 restart after lockout");
    goto_run();
    pos_short_i = 1'b1;
    ticks(3);
    chk(fault_o, 1, "R10 fault before lockout");
    pos_short_i = 1'b0;
    uvlo_i = 1'b1;
    step();
    chk(fault_o, 0, "R10 lockout clears fault");
    uvlo_i = 1'b0;
    step();
    chk(pos_run_o, 1, "R10 restart from fault via lockout");
    chk(fault_code_o, 0, "R10 code cleared on restart");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_normal_start();
    t_start_faults();
    t_pos_short();
    t_neg_short();
    t_thermal();
    t_uvlo();
    finish_run();
  end

endmodule